// File: doc/BRIEF.md
# Binary Shape Correlation Search

The block finds where a small square binary shape sits inside a larger square binary search window. Both images use one bit per pixel. Software or an upstream engine writes the shape (M x M bits) and the window (N x N bits) one row per cycle through a plain write port. A start pulse then launches an exhaustive scan over every placement of the shape inside the window. For each placement the block counts the pixel positions where the shape bit and the underlying window bit agree.

Several matching units work side by side. Each unit owns one horizontal offset of a group of neighbouring offsets, and each unit compares one shape row per cycle. When the scan ends the block pulses a done flag and presents the highest agreement count with its coordinates. On request it also emits every individual score as the scan proceeds, one group of units at a time.

Sizes are parameters: shape side M, window side N and unit count P. A typical build pairs a shape with a window twice as wide, for example 32 and 64, with 8 or 16 units. The defaults are kept small.

Top module: `bss_top`

## Requirements
- R1: After reset `busy`, `done` and every `str_valid` bit are 0. `best_score`, `best_i` and `best_j` are 0.
- R2: When `load_we` is high and the block is idle, `load_sel`=0 writes bits [M-1:0] of `load_data` into shape row `load_row`, where bit x is column x. A shape row index of M or more is ignored. `load_sel`=1 writes all N bits into window row `load_row`, where bit c is column c.
- R3: The score at offset (i,j) is the number of (x,y), with x and y in 0..M-1, for which shape row y bit x equals window row j+y bit i+x.
- R4: The scan covers every offset with i and j each in 0..N-M, that is G=N-M+1 values per axis.
- R5: A `start` pulse while idle raises `busy` in the next cycle. `done` is high for exactly one cycle, starting after the M*ceil(G/P)*G-th rising edge that follows the start edge. `busy` falls in that same cycle.
- R6: When `done` is high, `best_score` holds the highest score over all offsets. `best_i`/`best_j` hold the first offset that reaches it in raster order, with j as the outer loop and i as the inner loop.
- R7: When `stream_en` is high at the start edge, every group of P offsets (i = `str_i0`+u for unit u, row `str_j`) presents its scores on `str_score` lane u for one cycle. Lane u carries bits [u*SW +: SW] of `str_score`. When `stream_en` is low, `str_valid` stays 0.
- R8: Writes through the load port while `busy` is high are ignored. The stored shape and window are unchanged.
- R9: A `start` pulse while `busy` is high is ignored. The running scan keeps its timing and its result.
- R10: A lane whose offset str_i0+u is G or more, which happens in the last group when P does not divide G, has its `str_valid` bit low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_we | input | 1 | Row write strobe |
| load_sel | input | 1 | 0 = shape row, 1 = window row |
| load_row | input | RW=$clog2(N) | Row index |
| load_data | input | N | Row bits, bit c = column c |
| start | input | 1 | Launch a scan (idle only) |
| stream_en | input | 1 | Emit per-offset scores during the scan |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan flag |
| best_score | output | SW | Highest score |
| best_i | output | CW | Column offset of the best score |
| best_j | output | CW | Row offset of the best score |
| str_valid | output | P | Per-lane stream valid |
| str_score | output | P*SW | Per-lane stream scores |
| str_i0 | output | CW | Column offset of lane 0 |
| str_j | output | CW | Row offset of the streamed group |

## Verification
The start edge is counted as edge zero. `busy` is due right after it, a group's scores are due after every M-th following edge, and `done` with the final best is due after edge M*ceil(G/P)*G. That is 60 edges with the default M=4, N=8, P=2. The bench drives every input on the falling edge and samples there as well. It counts rising edges from the start edge, so each stream event and the done flag are matched against the exact edge number where they must appear. The bench injects a rejected row write and a second start at fixed edge counts inside a scan. It then checks that the done edge and all scores still match a model that never saw those writes.

// File: rtl/bss_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the binary shape search block.
// Assumes nothing beyond a single clock domain.
package bss_pkg;
    // Target of a row write on the load port.
    typedef enum logic {
        TGT_SHAPE  = 1'b0,
        TGT_WINDOW = 1'b1
    } load_tgt_e;
endpackage

// File: rtl/bss_unit.sv
`timescale 1ns/1ps
// One matching unit: compares one shape row against the window row
// slice at its column offset each cycle and accumulates the agreement count.
// Assumes the caller pulses last_row on the final row of each offset;
// total is the full score in that cycle.
module bss_unit #(
    parameter int M  = 4,
    parameter int N  = 8,
    parameter int SW = 5,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    input  logic          last_row,
    input  logic [M-1:0]  shape_row,
    input  logic [N-1:0]  win_row,
    input  logic [IW-1:0] i_off,
    output logic [SW-1:0] total
);
    logic [M-1:0]  slice;
    logic [M-1:0]  agree;
    logic [SW-1:0] pc;
    logic [SW-1:0] acc;

    // Window bits under the shape row, then the agreeing positions.
    always_comb begin
        slice = M'(win_row >> i_off);
        agree = ~(slice ^ shape_row);
    end

    // Count agreeing positions in the current row.
    always_comb begin
        pc = '0;
        for (int k = 0; k < M; k++) pc = pc + SW'(agree[k]);
    end

    assign total = acc + pc;

    // Running sum over rows; restarts after the last row of an offset.
    always_ff @(posedge clk) begin
        if (!rst_n)        acc <= '0;
        else if (clear)    acc <= '0;
        else if (step)     acc <= last_row ? '0 : total;
    end
endmodule

// File: rtl/bss_best.sv
`timescale 1ns/1ps
// Best-score tracker: picks the first strict maximum among the valid
// lanes of a group, then keeps it only if it beats the running best.
// Assumes groups arrive in raster order (j outer, i inner).
module bss_best #(
    parameter int P  = 2,
    parameter int SW = 5,
    parameter int CW = 3,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          upd,
    input  logic [P*SW-1:0] totals,
    input  logic [P-1:0]  lane_ok,
    input  logic [IW-1:0] i_base,
    input  logic [CW-1:0] j_cur,
    output logic [SW-1:0] best_score,
    output logic [CW-1:0] best_i,
    output logic [CW-1:0] best_j
);
    localparam int UW = (P > 1) ? $clog2(P) : 1;

    logic [SW-1:0] g_max;
    logic [UW-1:0] g_idx;
    logic          g_any;

    // First strict maximum across valid lanes, lowest lane wins ties.
    always_comb begin
        g_max = '0;
        g_idx = '0;
        g_any = 1'b0;
        for (int u = 0; u < P; u++) begin
            if (lane_ok[u] && (!g_any || totals[u*SW +: SW] > g_max)) begin
                g_max = totals[u*SW +: SW];
                g_idx = UW'(u);
                g_any = 1'b1;
            end
        end
    end

    // Running best; a later equal score never replaces an earlier one.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            best_score <= '0;
            best_i     <= '0;
            best_j     <= '0;
        end else if (upd && g_any && g_max > best_score) begin
            best_score <= g_max;
            best_i     <= CW'(i_base + IW'(g_idx));
            best_j     <= j_cur;
        end
    end
endmodule

// File: rtl/bss_top.sv
`timescale 1ns/1ps
// Binary shape correlation search. Holds an M x M shape and an N x N
// window, scans all (N-M+1)^2 offsets with P parallel units (one column
// offset each) and one shape row per cycle, and reports the best score.
// Assumes N >= M >= 2 and that loads happen only while idle.
module bss_top
    import bss_pkg::*;
#(
    parameter int M = 4,
    parameter int N = 8,
    parameter int P = 2,
    localparam int G  = N - M + 1,
    localparam int NG = (G + P - 1) / P,
    localparam int SW = $clog2(M*M + 1),
    localparam int CW = (G > 1) ? $clog2(G) : 1,
    localparam int RW = $clog2(N),
    localparam int YW = $clog2(M),
    localparam int GW = (NG > 1) ? $clog2(NG) : 1,
    localparam int IW = $clog2(N + P + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_we,
    input  logic            load_sel,
    input  logic [RW-1:0]   load_row,
    input  logic [N-1:0]    load_data,
    input  logic            start,
    input  logic            stream_en,
    output logic            busy,
    output logic            done,
    output logic [SW-1:0]   best_score,
    output logic [CW-1:0]   best_i,
    output logic [CW-1:0]   best_j,
    output logic [P-1:0]    str_valid,
    output logic [P*SW-1:0] str_score,
    output logic [CW-1:0]   str_i0,
    output logic [CW-1:0]   str_j
);
    logic [M-1:0]    shape_mem [M];
    logic [N-1:0]    win_mem   [N];
    logic [YW-1:0]   y_cnt;
    logic [GW-1:0]   g_cnt;
    logic [CW-1:0]   j_cnt;
    logic            strm_q;
    logic            last_row;
    logic            launch;
    logic [IW-1:0]   i_base;
    logic [N-1:0]    win_row;
    logic [M-1:0]    shape_row;
    logic [P-1:0]    lane_ok;
    logic [P*SW-1:0] totals;

    assign launch    = start && !busy;
    assign last_row  = (y_cnt == YW'(M - 1));
    assign i_base    = IW'(g_cnt) * IW'(P);
    assign win_row   = win_mem[RW'(j_cnt) + RW'(y_cnt)];
    assign shape_row = shape_mem[y_cnt];

    // Row storage; writes are accepted only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < M; r++) shape_mem[r] <= '0;
            for (int r = 0; r < N; r++) win_mem[r]   <= '0;
        end else if (load_we && !busy) begin
            if (load_tgt_e'(load_sel) == TGT_SHAPE) begin
                if (load_row < RW'(M)) shape_mem[YW'(load_row)] <= load_data[M-1:0];
            end else begin
                win_mem[load_row] <= load_data;
            end
        end
    end

    // Scan sequencer: row inner, column group middle, window row outer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            strm_q <= 1'b0;
            y_cnt  <= '0;
            g_cnt  <= '0;
            j_cnt  <= '0;
        end else begin
            done <= 1'b0;
            if (launch) begin
                busy   <= 1'b1;
                strm_q <= stream_en;
                y_cnt  <= '0;
                g_cnt  <= '0;
                j_cnt  <= '0;
            end else if (busy) begin
                if (!last_row) begin
                    y_cnt <= y_cnt + 1'b1;
                end else begin
                    y_cnt <= '0;
                    if (g_cnt != GW'(NG - 1)) begin
                        g_cnt <= g_cnt + 1'b1;
                    end else begin
                        g_cnt <= '0;
                        if (j_cnt != CW'(G - 1)) begin
                            j_cnt <= j_cnt + 1'b1;
                        end else begin
                            busy <= 1'b0;
                            done <= 1'b1;
                        end
                    end
                end
            end
        end
    end

    // One matching unit per column offset of the current group.
    for (genvar u = 0; u < P; u++) begin : g_unit
        logic [IW-1:0] unit_i;
        assign unit_i     = i_base + IW'(u);
        assign lane_ok[u] = (unit_i < IW'(G));
        bss_unit #(.M(M), .N(N), .SW(SW), .IW(IW)) u_unit (
            .clk       (clk),
            .rst_n     (rst_n),
            .clear     (launch),
            .step      (busy),
            .last_row  (last_row),
            .shape_row (shape_row),
            .win_row   (win_row),
            .i_off     (unit_i),
            .total     (totals[u*SW +: SW])
        );
    end

    // Score stream: one registered group per completed offset set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            str_valid <= '0;
            str_score <= '0;
            str_i0    <= '0;
            str_j     <= '0;
        end else begin
            str_valid <= '0;
            if (busy && last_row && strm_q) begin
                str_valid <= lane_ok;
                str_score <= totals;
                str_i0    <= CW'(i_base);
                str_j     <= j_cnt;
            end
        end
    end

    bss_best #(.P(P), .SW(SW), .CW(CW), .IW(IW)) u_best (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (launch),
        .upd        (busy && last_row),
        .totals     (totals),
        .lane_ok    (lane_ok),
        .i_base     (i_base),
        .j_cur      (j_cnt),
        .best_score (best_score),
        .best_i     (best_i),
        .best_j     (best_j)
    );
endmodule

// File: rtl/bss_checker.sv
`timescale 1ns/1ps
// Protocol and range properties for bss_top, attached through bind.
// Assumes the same parameters as the bound instance.
module bss_checker #(
    parameter int M = 4,
    parameter int N = 8,
    parameter int P = 2,
    localparam int G  = N - M + 1,
    localparam int SW = $clog2(M*M + 1),
    localparam int CW = (G > 1) ? $clog2(G) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [SW-1:0] best_score,
    input logic [CW-1:0] best_i,
    input logic [CW-1:0] best_j,
    input logic [P-1:0]  str_valid
);
    p_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_ends_scan_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    p_best_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (best_score <= SW'(M*M)) && (best_i <= CW'(G - 1)) && (best_j <= CW'(G - 1)));

    p_stream_in_scan_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|str_valid) |-> $past(busy));

    p_restart_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> (busy || done));
endmodule

bind bss_top bss_checker #(.M(M), .N(N), .P(P)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .best_score (best_score),
    .best_i     (best_i),
    .best_j     (best_j),
    .str_valid  (str_valid)
);

// File: tb/bss_top_test.sv
`timescale 1ns/1ps
// Self-checking bench for bss_top with M=4, N=8, P=2.
module bss_top_test;
    localparam int M  = 4;
    localparam int N  = 8;
    localparam int P  = 2;
    localparam int G  = N - M + 1;
    localparam int NG = (G + P - 1) / P;
    localparam int SW = $clog2(M*M + 1);
    localparam int CW = (G > 1) ? $clog2(G) : 1;
    localparam int RW = $clog2(N);
    localparam int EXP_CYC = M * NG * G;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            load_we = 1'b0;
    logic            load_sel = 1'b0;
    logic [RW-1:0]   load_row = '0;
    logic [N-1:0]    load_data = '0;
    logic            start = 1'b0;
    logic            stream_en = 1'b0;
    logic            busy, done;
    logic [SW-1:0]   best_score;
    logic [CW-1:0]   best_i, best_j;
    logic [P-1:0]    str_valid;
    logic [P*SW-1:0] str_score;
    logic [CW-1:0]   str_i0, str_j;

    int n_tests = 0;
    int n_fail  = 0;

    logic [M-1:0] sh [M];
    logic [N-1:0] wn [N];

    always #4ns clk = ~clk;

    bss_top #(.M(M), .N(N), .P(P)) uut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model_score(input int i, input int j);
        int s = 0;
        for (int y = 0; y < M; y++)
            for (int x = 0; x < M; x++)
                if (sh[y][x] == wn[j+y][i+x]) s++;
        return s;
    endfunction

    task automatic write_row(input bit sel, input int row, input logic [N-1:0] d);
        @(negedge clk);
        load_we = 1'b1; load_sel = sel; load_row = RW'(row); load_data = d;
        @(negedge clk);
        load_we = 1'b0;
        if (!sel && row < M) sh[row] = d[M-1:0];
        if (sel) wn[row] = d;
    endtask

    task automatic run_search(input bit sen, input bit inject, input string tag);
        int eb = -1, ei = 0, ej = 0, cnt = 0, nstr = 0;
        for (int j = 0; j < G; j++)
            for (int i = 0; i < G; i++)
                if (model_score(i, j) > eb) begin eb = model_score(i, j); ei = i; ej = j; end
        @(negedge clk);
        stream_en = sen; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, {"R5 busy after start ", tag}, int'(busy), 1);
        do begin
            @(negedge clk);
            cnt++;
            if (inject) begin
                if (cnt == 10) begin load_we = 1'b1; load_sel = 1'b1; load_row = 3; load_data = ~wn[3]; end
                if (cnt == 11) load_we = 1'b0;
                if (cnt == 14) begin load_we = 1'b1; load_sel = 1'b0; load_row = 1; load_data = ~{{(N-M){1'b0}}, sh[1]}; end
                if (cnt == 15) load_we = 1'b0;
                if (cnt == 20) start = 1'b1;
                if (cnt == 21) start = 1'b0;
            end
            if (|str_valid) begin
                chk(cnt % M == 0, {"R7 stream edge ", tag}, cnt % M, 0);
                for (int u = 0; u < P; u++) begin
                    int ii = int'(str_i0) + u;
                    chk(str_valid[u] == (ii < G), {"R10 lane mask ", tag}, int'(str_valid[u]), int'(ii < G));
                    if (ii < G && str_valid[u]) begin
                        nstr++;
                        chk(int'(str_score[u*SW +: SW]) == model_score(ii, int'(str_j)),
                            {"R3 R4 stream score ", tag}, int'(str_score[u*SW +: SW]), model_score(ii, int'(str_j)));
                    end
                end
            end
        end while (!done && cnt < 500);
        chk(cnt == EXP_CYC, {"R5 done edge ", tag}, cnt, EXP_CYC);
        chk(busy === 1'b0, {"R5 busy at done ", tag}, int'(busy), 0);
        chk(int'(best_score) == eb, {"R6 R3 best score ", tag}, int'(best_score), eb);
        chk(int'(best_i) == ei, {"R6 best i ", tag}, int'(best_i), ei);
        chk(int'(best_j) == ej, {"R6 best j ", tag}, int'(best_j), ej);
        chk(nstr == (sen ? G*G : 0), {"R7 R4 stream count ", tag}, nstr, sen ? G*G : 0);
        @(negedge clk);
        chk(done === 1'b0, {"R5 done one cycle ", tag}, int'(done), 0);
    endtask

    task automatic fill(input logic [M-1:0] s [M], input logic [N-1:0] w [N]);
        for (int r = 0; r < M; r++) write_row(1'b0, r, N'(s[r]));
        for (int r = 0; r < N; r++) write_row(1'b1, r, w[r]);
    endtask

    initial begin
        #(8ns * 150000);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [M-1:0] s [M];
        logic [N-1:0] w [N];
        for (int r = 0; r < M; r++) sh[r] = '0;
        for (int r = 0; r < N; r++) wn[r] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy === 1'b0 && done === 1'b0 && str_valid === '0, "R1 control idle", int'(busy), 0);
        chk(best_score === '0 && best_i === '0 && best_j === '0, "R1 best cleared", int'(best_score), 0);

        // All zeros: every score is M*M, tie keeps (0,0)
        run_search(1'b1, 1'b0, "all-zero");

        // Shape ones, window zeros: every score 0
        for (int r = 0; r < M; r++) s[r] = '1;
        for (int r = 0; r < N; r++) w[r] = '0;
        fill(s, w);
        run_search(1'b0, 1'b0, "no-agree");

        // Random shapes embedded at corners and middle
        for (int t = 0; t < 6; t++) begin
            int oi = (t == 0) ? G-1 : (t == 1) ? 0 : t % G;
            int oj = (t == 0) ? G-1 : (t == 1) ? 0 : (t * 3) % G;
            for (int r = 0; r < M; r++) s[r] = M'($urandom);
            for (int r = 0; r < N; r++) w[r] = N'($urandom);
            for (int y = 0; y < M; y++)
                for (int x = 0; x < M; x++) w[oj+y][oi+x] = s[y][x];
            fill(s, w);
            run_search(t[0], 1'b0, $sformatf("embed%0d", t));
        end

        // R2 shape row index beyond M is ignored
        write_row(1'b0, M, '1);
        run_search(1'b1, 1'b0, "R2 oob shape row");

        // R8 R9 loads and start during scan are ignored
        run_search(1'b1, 1'b1, "R8 R9 inject");
        run_search(1'b1, 1'b0, "R8 rerun");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule